// File: doc/BRIEF.md
# Absolute-Difference Accumulate ALU

This block is a 64-bit integer execution unit for a small group of media-style instructions. A 10-bit extended opcode picks one of four operations: absolute difference, absolute difference added to an accumulator (unsigned or two's-complement), and a rounded average of two operands. The old destination value arrives on its own port and serves as the accumulator input, so a running sum of absolute differences builds up over a series of issues.

Operands are presented with a valid strobe. The result appears from a register one cycle later. When the record bit is set, a 4-bit condition field is also produced from the result. An opcode outside the set produces no result and raises an illegal-operation pulse instead. Register-file access and full instruction decode are handled elsewhere.

Top module: `absdiff_alu`

## Requirements
- R1: Opcode 1011110110 gives result = |A − B| with A and B taken as unsigned 64-bit values; the accumulator input is ignored.
- R2: Opcode 1111110110 gives result = ACC + |A − B| (unsigned), wrapping modulo 2^64 with no overflow indication; from ACC = 0, pairs (2,1) then (9,3) with the first result fed back give 7.
- R3: Opcode 0111110110 is the same as R2 except A and B are two's-complement; bit 9 of the opcode alone selects unsigned (1) or signed (0). From ACC = 0, pairs (2,−1) then (9,3) give 9.
- R4: Opcode 1101001110 gives result = (A + B + 1) >> 1 computed with a 65-bit sum, so no carry is lost.
- R5: out_valid is high in exactly the cycle after an accepted issue with a legal opcode and low in every other cycle; out_result is registered.
- R6: With rec_en set on a legal issue, out_cr_wr pulses with out_valid and out_cr = {LT, GT, EQ, SO} (bit 3 LT, bit 2 GT, bit 1 EQ, bit 0 SO): LT, GT, EQ compare the result as a signed value with 0, exactly one of them is set, and SO copies so_in.
- R7: With rec_en clear, out_cr_wr stays low and out_cr keeps its previous value.
- R8: An issue with any other opcode leaves out_valid low, raises out_illegal for one cycle, and changes neither out_result nor out_cr.
- R9: After reset out_valid, out_illegal and out_cr_wr are low and out_result and out_cr are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Issue strobe for the operands below |
| xop | input | 10 | Extended opcode |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| src_acc | input | 64 | Old destination value, accumulator input |
| rec_en | input | 1 | Request condition-field update |
| so_in | input | 1 | Summary-overflow bit copied into the condition field |
| out_valid | output | 1 | Result valid |
| out_result | output | 64 | Registered result |
| out_cr_wr | output | 1 | Condition field written this cycle |
| out_cr | output | 4 | Condition field {LT, GT, EQ, SO} |
| out_illegal | output | 1 | One-cycle pulse for an unknown opcode |

## Verification
Every result, condition field and illegal pulse is due exactly one clock edge after the issue that caused it, since one register sits between the operand ports and all outputs. The driver tags each expected item with the edge number at which it becomes visible, and the monitor compares only at the falling edge that follows that rising edge, so no sample falls on the edge where the outputs change. Idle cycles also push items that expect out_valid, out_illegal and out_cr_wr low and the condition field unchanged.

// File: rtl/absalu_pkg.sv
package absalu_pkg;

    localparam int OPW = 10;

    // opcodes that the decoder recognises
    localparam logic [OPW-1:0] XOP_ABSD   = 10'b1011110110;
    localparam logic [OPW-1:0] XOP_ACC_U  = 10'b1111110110;
    localparam logic [OPW-1:0] XOP_ACC_S  = 10'b0111110110;
    localparam logic [OPW-1:0] XOP_AVG    = 10'b1101001110;

    // condition field bit positions
    localparam int CR_LT = 3;
    localparam int CR_GT = 2;
    localparam int CR_EQ = 1;
    localparam int CR_SO = 0;
    localparam int CRW   = 4;

    typedef enum logic [2:0] {
        KIND_NONE,
        KIND_ABSD,
        KIND_ACC_U,
        KIND_ACC_S,
        KIND_AVG
    } alu_kind_e;

endpackage

// File: rtl/absalu_decode.sv
module absalu_decode
    import absalu_pkg::*;
(
    input  logic [OPW-1:0] xop,
    output alu_kind_e      kind,
    output logic           legal
);
    // the two accumulate forms share their low bits; the top bit chooses signedness
    localparam logic [OPW-2:0] ACC_LOW = XOP_ACC_U[OPW-2:0];

    always_comb begin
        kind = KIND_NONE;
        if (xop[OPW-2:0] == ACC_LOW) begin
            kind = xop[OPW-1] ? KIND_ACC_U : KIND_ACC_S;
        end else if (xop == XOP_ABSD) begin
            kind = KIND_ABSD;
        end else if (xop == XOP_AVG) begin
            kind = KIND_AVG;
        end
        legal = (kind != KIND_NONE);
    end
endmodule

// File: rtl/absalu_absdiff.sv
module absalu_absdiff #(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         signed_mode,
    output logic [W-1:0] abs_o
);
    localparam int WX = W + 1;

    logic [WX-1:0] a_x;
    logic [WX-1:0] b_x;
    logic [WX-1:0] diff_x;
    logic [W-1:0]  diff_rev;
    logic          a_below;

    always_comb begin
        // widen by one bit with zero or sign so the top bit of the
        // difference tells which operand is smaller
        a_x      = {signed_mode & a[W-1], a};
        b_x      = {signed_mode & b[W-1], b};
        diff_x   = a_x - b_x;
        a_below  = diff_x[WX-1];
        diff_rev = b - a;
        abs_o    = a_below ? diff_rev : diff_x[W-1:0];
    end
endmodule

// File: rtl/absalu_avg.sv
module absalu_avg #(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] avg_o
);
    localparam int WS = W + 1;

    logic [WS-1:0] sum;

    always_comb begin
        sum   = {1'b0, a} + {1'b0, b} + WS'(1);
        avg_o = W'(sum >> 1);
    end
endmodule

// File: rtl/absalu_crgen.sv
module absalu_crgen
    import absalu_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0]   value,
    input  logic           so,
    output logic [CRW-1:0] cr
);
    logic is_zero;
    logic is_neg;

    always_comb begin
        is_zero   = (value == '0);
        is_neg    = value[W-1];
        cr        = '0;
        cr[CR_LT] = is_neg;
        cr[CR_GT] = !is_neg && !is_zero;
        cr[CR_EQ] = is_zero;
        cr[CR_SO] = so;
    end
endmodule

// File: rtl/absdiff_alu.sv
module absdiff_alu
    import absalu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [9:0]      xop,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    input  logic [XLEN-1:0] src_acc,
    input  logic            rec_en,
    input  logic            so_in,
    output logic            out_valid,
    output logic [XLEN-1:0] out_result,
    output logic            out_cr_wr,
    output logic [3:0]      out_cr,
    output logic            out_illegal
);
    typedef struct packed {
        logic            valid;
        logic            illegal;
        logic [XLEN-1:0] result;
        logic            cr_wr;
        logic [CRW-1:0]  cr;
    } alu_state_t;

    alu_state_t state_d, state_q;

    alu_kind_e       kind;
    logic            legal;
    logic [XLEN-1:0] abs_val;
    logic [XLEN-1:0] avg_val;
    logic [XLEN-1:0] res_val;
    logic [CRW-1:0]  cr_val;
    logic            signed_sel;

    absalu_decode u_decode (
        .xop   (xop),
        .kind  (kind),
        .legal (legal)
    );

    assign signed_sel = (kind == KIND_ACC_S);

    absalu_absdiff #(.W(XLEN)) u_absdiff (
        .a           (src_a),
        .b           (src_b),
        .signed_mode (signed_sel),
        .abs_o       (abs_val)
    );

    absalu_avg #(.W(XLEN)) u_avg (
        .a     (src_a),
        .b     (src_b),
        .avg_o (avg_val)
    );

    always_comb begin
        unique case (kind)
            KIND_ACC_U, KIND_ACC_S: res_val = src_acc + abs_val;
            KIND_AVG:               res_val = avg_val;
            default:                res_val = abs_val;
        endcase
    end

    absalu_crgen #(.W(XLEN)) u_crgen (
        .value (res_val),
        .so    (so_in),
        .cr    (cr_val)
    );

    always_comb begin
        state_d         = state_q;
        state_d.valid   = 1'b0;
        state_d.illegal = 1'b0;
        state_d.cr_wr   = 1'b0;
        if (in_valid) begin
            if (legal) begin
                state_d.valid  = 1'b1;
                state_d.result = res_val;
                if (rec_en) begin
                    state_d.cr_wr = 1'b1;
                    state_d.cr    = cr_val;
                end
            end else begin
                state_d.illegal = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid   = state_q.valid;
    assign out_illegal = state_q.illegal;
    assign out_result  = state_q.result;
    assign out_cr_wr   = state_q.cr_wr;
    assign out_cr      = state_q.cr;

    // a result only follows an issue one cycle earlier
    assert_valid_after_issue_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid)
    );

    // an unknown opcode never produces a result alongside its flag
    assert_illegal_no_result_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        out_illegal |-> (!out_valid && !out_cr_wr && $stable(out_result))
    );

    // no write, no change of the condition field
    assert_cr_hold_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        !out_cr_wr |-> $stable(out_cr)
    );

    // exactly one comparison bit when the field is written
    assert_cr_single_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        out_cr_wr |-> ($countones(out_cr[CR_LT:CR_EQ]) == 1 && out_valid)
    );

    // the equal bit agrees with the registered result
    assert_cr_eq_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        out_cr_wr |-> (out_cr[CR_EQ] == (out_result == '0))
    );
endmodule

// File: tb/absdiff_alu_test.sv
module absdiff_alu_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [9:0]  xop = '0;
    logic [63:0] src_a = '0, src_b = '0, src_acc = '0;
    logic        rec_en = 1'b0, so_in = 1'b0;
    logic        out_valid, out_cr_wr, out_illegal;
    logic [63:0] out_result;
    logic [3:0]  out_cr;

    absdiff_alu uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .xop(xop),
        .src_a(src_a), .src_b(src_b), .src_acc(src_acc),
        .rec_en(rec_en), .so_in(so_in),
        .out_valid(out_valid), .out_result(out_result),
        .out_cr_wr(out_cr_wr), .out_cr(out_cr), .out_illegal(out_illegal)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic        v;
        logic        ill;
        logic [63:0] res;
        logic        crw;
        logic [3:0]  cr;
        longint      due;
        string       req;
    } exp_t;

    exp_t        sbq[$];
    longint      cyc = 0;
    int          errors = 0;
    int          checks = 0;
    bit          mon_on = 1'b0;
    logic [3:0]  cr_model = '0;
    logic [63:0] res_model = '0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [63:0] abs_of(input logic [63:0] a, input logic [63:0] b, input bit sgn);
        bit lt;
        lt = sgn ? ($signed(a) < $signed(b)) : (a < b);
        return lt ? (b - a) : (a - b);
    endfunction

    task automatic issue(input logic [9:0] op, input logic [63:0] a, input logic [63:0] b,
                         input logic [63:0] acc, input bit rec, input bit so, input string req);
        exp_t e;
        logic [64:0] s;
        bit ok;
        @(negedge clk);
        in_valid = 1'b1; xop = op; src_a = a; src_b = b; src_acc = acc;
        rec_en = rec; so_in = so;
        ok = 1'b1;
        case (op)
            10'b1011110110: e.res = abs_of(a, b, 1'b0);
            10'b1111110110: e.res = acc + abs_of(a, b, 1'b0);
            10'b0111110110: e.res = acc + abs_of(a, b, 1'b1);
            10'b1101001110: begin
                s = {1'b0, a} + {1'b0, b} + 65'd1;
                e.res = s[64:1];
            end
            default: begin ok = 1'b0; e.res = res_model; end
        endcase
        if (ok) res_model = e.res;
        if (ok && rec)
            cr_model = {$signed(e.res) < 0, $signed(e.res) > 0, e.res == 0, so};
        e.v = ok; e.ill = !ok; e.crw = ok && rec; e.cr = cr_model;
        e.due = cyc + 1; e.req = req;
        sbq.push_back(e);
    endtask

    task automatic idle(input string req);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b0; xop = 10'b1111110110; src_a = ONES; rec_en = 1'b1;
        e.v = 1'b0; e.ill = 1'b0; e.res = res_model; e.crw = 1'b0; e.cr = cr_model;
        e.due = cyc + 1; e.req = req;
        sbq.push_back(e);
    endtask

    // monitor: pops the item due at this cycle and compares every output
    always @(negedge clk) begin
        if (mon_on && sbq.size() > 0 && sbq[0].due == cyc) begin
            exp_t e;
            e = sbq.pop_front();
            checks++;
            if (out_valid !== e.v || out_illegal !== e.ill || out_cr_wr !== e.crw ||
                out_cr !== e.cr || out_result !== e.res) begin
                errors++;
                $display("FAIL %s: got v=%b ill=%b res=%h crw=%b cr=%b exp v=%b ill=%b res=%h crw=%b cr=%b",
                         e.req, out_valid, out_illegal, out_result, out_cr_wr, out_cr,
                         e.v, e.ill, e.res, e.crw, e.cr);
            end
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        checks++;
        if (out_valid !== 1'b0 || out_illegal !== 1'b0 || out_cr_wr !== 1'b0 ||
            out_cr !== 4'b0 || out_result !== 64'd0) begin
            errors++;
            $display("FAIL R9: got v=%b ill=%b crw=%b cr=%b res=%h exp all zero",
                     out_valid, out_illegal, out_cr_wr, out_cr, out_result);
        end
        rst_n = 1'b1;
        mon_on = 1'b1;
        idle("R5 idle after reset");

        // R1 unsigned absolute difference, accumulator ignored
        issue(10'b1011110110, 64'd5, 64'd3, 64'd100, 1'b0, 1'b0, "R1 5,3");
        issue(10'b1011110110, 64'd3, 64'd5, ONES, 1'b0, 1'b0, "R1 3,5");
        issue(10'b1011110110, 64'd0, ONES, 64'd7, 1'b1, 1'b0, "R1 R6 0,ones LT");
        issue(10'b1011110110, 64'd7, 64'd7, 64'd0, 1'b1, 1'b1, "R1 R6 equal EQ+SO");

        // R2 unsigned accumulate chain and wrap
        issue(10'b1111110110, 64'd2, 64'd1, 64'd0, 1'b0, 1'b0, "R2 step1");
        issue(10'b1111110110, 64'd9, 64'd3, 64'd1, 1'b1, 1'b0, "R2 R6 step2 GT");
        issue(10'b1111110110, 64'd1, 64'd0, ONES, 1'b1, 1'b1, "R2 wrap");
        issue(10'b1111110110, 64'd2, ONES, 64'd0, 1'b0, 1'b0, "R2 unsigned 2,ones");

        // R7 record clear keeps the field
        issue(10'b1011110110, 64'd10, 64'd4, 64'd0, 1'b0, 1'b1, "R7 hold");
        idle("R5 R7 idle hold");

        // R3 signed accumulate chain
        issue(10'b0111110110, 64'd2, ONES, 64'd0, 1'b0, 1'b0, "R3 step1");
        issue(10'b0111110110, 64'd9, 64'd3, 64'd3, 1'b1, 1'b0, "R3 step2");
        issue(10'b0111110110, 64'h8000_0000_0000_0000, 64'd1, 64'd0, 1'b1, 1'b0, "R3 min,1");

        // R4 rounded average
        issue(10'b1101001110, ONES, ONES, 64'd0, 1'b1, 1'b0, "R4 carry");
        issue(10'b1101001110, 64'd1, 64'd2, 64'd0, 1'b0, 1'b0, "R4 round up");
        issue(10'b1101001110, 64'd6, 64'd8, 64'd0, 1'b1, 1'b0, "R4 even");

        // R8 unknown opcodes, result and field unchanged
        issue(10'b0000000000, 64'd1, 64'd2, 64'd3, 1'b1, 1'b1, "R8 zero op");
        idle("R8 pulse ends");
        issue(10'b1111110111, 64'd4, 64'd2, 64'd3, 1'b1, 1'b0, "R8 near op");
        issue(10'b0011110110, 64'd4, 64'd2, 64'd3, 1'b1, 1'b0, "R8 bad top bits");
        issue(10'b1011110110, 64'd1, 64'd9, 64'd0, 1'b0, 1'b0, "R1 after illegal");

        idle("R5 drain");
        idle("R5 drain");
        while (sbq.size() > 0) @(negedge clk);
        finish_run();
    end
endmodule